// File: doc/BRIEF.md
# Negative-Scenario Exclusion and Forbiddance Monitor

This block watches two state levels and one event strobe from the logic around it. Each cycle it decides whether a forbidden ordering has just taken place, under one of four rules picked by a two-bit mode select. It works as a run-time observer, either inside a chip or beside a design under test. It reports the first and every later failure through a sticky violation flag and a one-cycle failure pulse.

A state is treated as a closed interval. Its start event is the first cycle its level reads 1 after reading 0. Its end event is the first cycle its level reads 0 after reading 1. An occurrence that lands on the end cycle still belongs to the interval. Mutual exclusion of two states is built from two one-way checks, each testing one state's interval against the other state's start event. The two forbiddance rules look at what holds when a state is left, or whether a state is entered at any time after an event has been seen.

Top module: `exmon_top`

## Requirements
- R1: While rstN is low, and in the first cycle after it, violation and failPulse are 0. Reset clears the remembered previous levels (treated as 0) and the armed condition of mode 3.
- R2: In mode 2'b00 (A excludes e), a failure occurs in a cycle where evtE is 1 and either stateA is 1 or stateA has just fallen (it is 0 now and was 1 in the previous cycle).
- R3: In mode 2'b00, evtE in a cycle where stateA is 0 and was 0 in the previous cycle causes no failure.
- R4: In mode 2'b01 (A excludes B), a failure occurs when stateB rises while A is inside its interval (stateA is 1, or it is the cycle A falls), and also when stateA rises while B is inside its interval. A simultaneous rise of both counts as a failure.
- R5: In mode 2'b01, a rise of one state while the other is 0 and outside its end cycle causes no failure.
- R6: In mode 2'b10 (A forbids B), a failure occurs in the cycle stateA falls if stateB is 1 in that cycle. stateB being 1 while stateA is 1 is not a failure by itself, and a fall of stateA with stateB at 0 is not a failure.
- R7: In mode 2'b11 (e forbids A), evtE arms the monitor from the next cycle on. A rise of stateA in any later cycle while armed is a failure. A rise of stateA in the same cycle as the arming evtE is not.
- R8: Once armed, mode 2'b11 stays armed for any number of cycles until reset, and only reset disarms it.
- R9: The outputs are registered. A failure in cycle k gives failPulse = 1 in cycle k+1 only, with one pulse per failing cycle. violation becomes 1 in cycle k+1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| stateA | input | 1 | Level of the first observed state |
| stateB | input | 1 | Level of the second observed state |
| evtE | input | 1 | Event strobe, one occurrence per cycle it is high |
| mode | input | 2 | Rule select: 00 A excl e, 01 A excl B, 10 A forbids B, 11 e forbids A |
| violation | output | 1 | Sticky flag, set by the first failure |
| failPulse | output | 1 | High for one cycle after each failing cycle |

## Verification
The monitor's internal state is small: the two remembered levels and the armed bit. A wrong previous level shows at the ports in the very next cycle, as a missed or spurious pulse on a rise or on an end-cycle occurrence. A lost or spurious armed bit shows only at the next rise of stateA in mode 3, however many cycles later that comes. For this reason the bench places rises directly after reset, on the end cycle of an interval, and after a long idle stretch while armed. A sticky flag that drops, or a pulse that stretches, shows one cycle after the failure.

// File: rtl/exmon_pkg.sv
package exmon_pkg;

  typedef enum logic [1:0] {
    MODE_A_EXCL_E = 2'b00,
    MODE_A_EXCL_B = 2'b01,
    MODE_A_FORB_B = 2'b10,
    MODE_E_FORB_A = 2'b11
  } monMode_t;

  localparam int NUM_CHECKS = 2;

  typedef struct packed {
    logic roseA;
    logic fallA;
    logic roseB;
    logic fallB;
    logic armed;
  } strobes_t;

endpackage

// File: rtl/exmon_window.sv
module exmon_window (
  input  logic inWin,
  input  logic trig,
  output logic hit
);
  // a point event counts when it lies inside the closed interval
  assign hit = inWin & trig;
endmodule

// File: rtl/exmon_ctrl.sv
module exmon_ctrl
  import exmon_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     stateA,
  input  logic     stateB,
  input  logic     evtE,
  input  monMode_t mode,
  output strobes_t strobes
);

  logic prevA;
  logic prevB;
  logic armedQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevA  <= 1'b0;
      prevB  <= 1'b0;
      armedQ <= 1'b0;
    end else begin
      prevA <= stateA;
      prevB <= stateB;
      if (mode == MODE_E_FORB_A && evtE) armedQ <= 1'b1;
    end
  end

  always_comb begin
    strobes.roseA = stateA & ~prevA;
    strobes.fallA = ~stateA & prevA;
    strobes.roseB = stateB & ~prevB;
    strobes.fallB = ~stateB & prevB;
    strobes.armed = armedQ;
  end

  // R8: nothing but reset disarms
  assert_armed_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.armed |=> strobes.armed);

  // R7: an event in mode 3 arms the monitor for the next cycle
  assert_event_arms_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_E_FORB_A && evtE) |=> strobes.armed);

endmodule

// File: rtl/exmon_eval.sv
module exmon_eval
  import exmon_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     stateA,
  input  logic     stateB,
  input  logic     evtE,
  input  monMode_t mode,
  input  strobes_t strobes,
  output logic     violation,
  output logic     failPulse
);

  logic [NUM_CHECKS-1:0] inWin;
  logic [NUM_CHECKS-1:0] trig;
  logic [NUM_CHECKS-1:0] hit;
  logic failNow;

  // check 0: interval of A against e (mode 0) or start of B (mode 1)
  // check 1: interval of B against start of A
  always_comb begin
    inWin[0] = stateA | strobes.fallA;
    trig[0]  = (mode == MODE_A_EXCL_E) ? evtE : strobes.roseB;
    inWin[1] = stateB | strobes.fallB;
    trig[1]  = strobes.roseA;
  end

  for (genvar i = 0; i < NUM_CHECKS; i++) begin : gChk
    exmon_window uWin (
      .inWin (inWin[i]),
      .trig  (trig[i]),
      .hit   (hit[i])
    );
  end

  always_comb begin
    unique case (mode)
      MODE_A_EXCL_E: failNow = hit[0];
      MODE_A_EXCL_B: failNow = |hit;
      MODE_A_FORB_B: failNow = strobes.fallA & stateB;
      MODE_E_FORB_A: failNow = strobes.armed & strobes.roseA;
      default:       failNow = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      violation <= 1'b0;
      failPulse <= 1'b0;
    end else begin
      violation <= violation | failNow;
      failPulse <= failNow;
    end
  end

  // R2: e inside A gives a pulse on the next cycle
  assert_excl_event_R2: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_A_EXCL_E && evtE && stateA) |=> failPulse);

  // R4: start of B inside A gives a pulse
  assert_excl_state_R4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_A_EXCL_B && stateA && strobes.roseB) |=> failPulse);

  // R7: entry into A while armed gives a pulse
  assert_forbid_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_E_FORB_A && strobes.armed && strobes.roseA) |=> failPulse);

  // R9: flag is sticky, pulse implies flag, new flag comes with a pulse
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    violation |=> violation);
  assert_pulse_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    failPulse |-> violation);
  assert_first_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(violation) |-> failPulse);

endmodule

// File: rtl/exmon_top.sv
module exmon_top
  import exmon_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stateA,
  input  logic       stateB,
  input  logic       evtE,
  input  logic [1:0] mode,
  output logic       violation,
  output logic       failPulse
);

  monMode_t modeSel;
  strobes_t strobes;

  assign modeSel = monMode_t'(mode);

  exmon_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .stateA  (stateA),
    .stateB  (stateB),
    .evtE    (evtE),
    .mode    (modeSel),
    .strobes (strobes)
  );

  exmon_eval uEval (
    .clk       (clk),
    .rstN      (rstN),
    .stateA    (stateA),
    .stateB    (stateB),
    .evtE      (evtE),
    .mode      (modeSel),
    .strobes   (strobes),
    .violation (violation),
    .failPulse (failPulse)
  );

endmodule

// File: tb/tb_exmon_top.sv
module tb_exmon_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stateA = 1'b0;
  logic stateB = 1'b0;
  logic evtE = 1'b0;
  logic [1:0] mode = 2'b00;
  logic violation;
  logic failPulse;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  exmon_top dut (
    .clk       (clk),
    .rstN      (rstN),
    .stateA    (stateA),
    .stateB    (stateB),
    .evtE      (evtE),
    .mode      (mode),
    .violation (violation),
    .failPulse (failPulse)
  );

  // fields: rstN, mode[1:0], a, b, e, expected pulse, expected violation
  localparam int NVEC = 44;
  localparam logic [7:0] VEC [NVEC] = '{
    8'b0_00_0_0_0_0_0, // R1 reset
    8'b1_00_0_0_1_0_0, // R3 e with A low
    8'b1_00_1_0_0_0_0,
    8'b1_00_1_0_1_1_1, // R2 e inside A
    8'b1_00_1_0_0_0_1, // R9 pulse drops, flag stays
    8'b0_00_0_0_0_0_0, // R1
    8'b1_00_1_0_0_0_0,
    8'b1_00_0_0_1_1_1, // R2 e on end cycle of A
    8'b1_00_0_0_1_0_1, // R3 e after end cycle
    8'b0_01_0_0_0_0_0,
    8'b1_01_1_0_0_0_0, // R5 A rises with B low
    8'b1_01_1_1_0_1_1, // R4 B rises inside A
    8'b0_01_0_0_0_0_0,
    8'b1_01_0_1_0_0_0, // R5 B rises with A low
    8'b1_01_1_1_0_1_1, // R4 A rises inside B
    8'b0_01_0_0_0_0_0,
    8'b1_01_1_0_0_0_0,
    8'b1_01_0_0_0_0_0,
    8'b1_01_0_1_0_0_0, // R5 B rises after A's end cycle
    8'b0_01_0_0_0_0_0,
    8'b1_01_1_0_0_0_0,
    8'b1_01_0_1_0_1_1, // R4 B rises on A's end cycle
    8'b0_10_0_0_0_0_0,
    8'b1_10_1_0_0_0_0,
    8'b1_10_1_1_0_0_0, // R6 B inside A alone is fine
    8'b1_10_0_1_0_1_1, // R6 A exits with B high
    8'b0_10_0_0_0_0_0,
    8'b1_10_1_1_0_0_0,
    8'b1_10_1_0_0_0_0,
    8'b1_10_0_0_0_0_0, // R6 A exits with B low
    8'b0_11_0_0_0_0_0,
    8'b1_11_0_0_1_0_0, // R7 arm
    8'b1_11_1_0_0_1_1, // R7 entry after e
    8'b0_11_0_0_0_0_0, // R1 reset disarms
    8'b1_11_1_0_1_0_0, // R7 entry in same cycle as e
    8'b1_11_0_0_0_0_0,
    8'b1_11_1_0_0_1_1, // R8 still armed
    8'b0_11_0_0_0_0_0,
    8'b1_11_0_0_0_0_0,
    8'b1_11_1_0_0_0_0, // R8 reset cleared arming
    8'b0_00_0_0_0_0_0,
    8'b1_00_1_0_1_1_1, // R9 first failure
    8'b1_00_1_0_1_1_1, // R9 second failure, second pulse
    8'b1_00_1_0_0_0_1  // R9 pulse ends, flag held
  };

  task automatic checkOut(input logic expP, input logic expV, input string req);
    checks++;
    if (failPulse !== expP || violation !== expV) begin
      errors++;
      $display("FAIL %s: pulse=%b violation=%b expected pulse=%b violation=%b",
               req, failPulse, violation, expP, expV);
    end
  endtask

  // drive just after a falling edge, sample at the next falling edge
  task automatic step(input logic r, input logic [1:0] m, input logic a,
                      input logic b, input logic e);
    rstN = r; mode = m; stateA = a; stateB = b; evtE = e;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
    checkOut(1'b0, 1'b0, "R1");
    step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
    checkOut(1'b0, 1'b0, "R1");

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][7], VEC[i][6:5], VEC[i][4], VEC[i][3], VEC[i][2]);
      checkOut(VEC[i][1], VEC[i][0], $sformatf("vector %0d", i));
    end

    // R8 long idle while armed, then entry
    step(1'b0, 2'b11, 1'b0, 1'b0, 1'b0);
    step(1'b1, 2'b11, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 300; k++) step(1'b1, 2'b11, 1'b0, 1'b0, 1'b0);
    checkOut(1'b0, 1'b0, "R8");
    step(1'b1, 2'b11, 1'b1, 1'b0, 1'b0);
    checkOut(1'b1, 1'b1, "R8");

    // R9 flag held for many cycles without new failures
    for (int k = 0; k < 50; k++) step(1'b1, 2'b11, 1'b1, 1'b0, 1'b0);
    checkOut(1'b0, 1'b1, "R9");

    // R2 A held high from reset release: e right away fails
    step(1'b0, 2'b00, 1'b1, 1'b0, 1'b0);
    checkOut(1'b0, 1'b0, "R1");
    step(1'b1, 2'b00, 1'b1, 1'b0, 1'b1);
    checkOut(1'b1, 1'b1, "R2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule